// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the program counter of a non-pipelined processor and works out the address of the next instruction. The counter is 16 bits wide and counts in 16-bit words, so stepping to the next instruction adds one. The control state machine raises an update strobe once per instruction. On that clock edge the counter moves to one of four places:
- the next word;
- a relative target, which is the counter plus a signed offset;
- an absolute target taken from a register operand;
- the same absolute target, while the return address is also handed to the register file.

The instruction decoder supplies a two-bit transfer class and the sign-extended offset. The branch unit supplies a taken flag, and the register file supplies the operand. In the update that performs a call, the unit also gives out the return address, which is the old counter plus one, together with a one-cycle write request. This lets the register file store the return address even when the target register and the link register are the same one.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes 0x0000, `link_o` becomes 0x0000 and `link_wr_o` becomes 0.
- R2: A rising edge with `upd_en` low leaves `pc_o` and `link_o` unchanged and drives `link_wr_o` to 0, whatever the class, flag, offset and operand inputs are.
- R3: An update with class 0 (sequential) sets `pc_o` to the old value plus 1, modulo 2^16. So 0xFFFF steps to 0x0000.
- R4: An update with class 1 (relative) and `br_taken` high sets `pc_o` to the old value plus `br_ofs`, modulo 2^16. Overflow is not flagged.
- R5: An update with class 1 and `br_taken` low sets `pc_o` to the old value plus 1.
- R6: An update with class 2 (jump) loads `pc_o` from `reg_val` and leaves `link_wr_o` at 0.
- R7: An update with class 3 (jump with link) loads `pc_o` from `reg_val` and raises `link_wr_o` for exactly the one cycle after that edge.
- R8: After every update, `link_o` holds the counter value from before that update plus 1, modulo 2^16.
- R9: `br_taken` has no effect on classes 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Update strobe from the control state machine |
| xfer_kind | input | 2 | Transfer class: 0 sequential, 1 relative, 2 jump, 3 jump with link |
| br_taken | input | 1 | Branch condition result, used by class 1 only |
| br_ofs | input | 16 | Sign-extended branch offset, in words |
| reg_val | input | 16 | Register operand that holds the jump target |
| pc_o | output | 16 | Current program counter |
| link_o | output | 16 | Return address: the old counter plus one, captured at the last update |
| link_wr_o | output | 1 | One-cycle register-file write request for the link value |

## Verification
The bench builds the unit with its default 16-bit counter. With that width the wraparound cases can be reached in a few steps. A jump to 0xFFFF followed by a sequential step shows the counter rolling over to zero. A negative offset taken from address zero shows a relative target wrapping backwards. The bench also issues a call whose target equals the current counter. This shows that the return address is taken from the value before the update and not from the new one.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Transfer class. The encoding is decoded by the instruction decoder.
  typedef enum logic [1:0] {
    XF_SEQ  = 2'd0,
    XF_REL  = 2'd1,
    XF_JMP  = 2'd2,
    XF_CALL = 2'd3
  } xfer_t;

endpackage

// File: rtl/pcu_adder.sv
module pcu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  // Modulo-2^W sum. Any carry out of the top bit is dropped.
  always_comb sum_o = a_i + b_i;
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
  import pcu_pkg::*;
#(
  parameter int W = 16
) (
  input  xfer_t        kind_i,
  input  logic         taken_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] rel_i,
  input  logic [W-1:0] abs_i,
  output logic [W-1:0] next_o,
  output logic         call_o
);
  always_comb begin
    next_o = inc_i;
    call_o = 1'b0;
    unique case (kind_i)
      XF_SEQ:  next_o = inc_i;
      XF_REL:  next_o = taken_i ? rel_i : inc_i;
      XF_JMP:  next_o = abs_i;
      XF_CALL: begin
        next_o = abs_i;
        call_o = 1'b1;
      end
      default: next_o = inc_i;
    endcase
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcu_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_en,
  input  logic [1:0]      xfer_kind,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_ofs,
  input  logic [PC_W-1:0] reg_val,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] link_o,
  output logic            link_wr_o
);
  localparam logic [PC_W-1:0] ONE  = PC_W'(1);
  localparam logic [PC_W-1:0] ZERO = '0;

  xfer_t           kind;
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_rel;
  logic [PC_W-1:0] pc_nxt;
  logic            is_call;

  assign kind = xfer_t'(xfer_kind);

  // Sequential successor. It is also the return address.
  pcu_adder #(.W(PC_W)) u_inc (
    .a_i(pc_o), .b_i(ONE), .sum_o(pc_inc)
  );

  // Relative target.
  pcu_adder #(.W(PC_W)) u_rel (
    .a_i(pc_o), .b_i(br_ofs), .sum_o(pc_rel)
  );

  pcu_next_sel #(.W(PC_W)) u_sel (
    .kind_i (kind),
    .taken_i(br_taken),
    .inc_i  (pc_inc),
    .rel_i  (pc_rel),
    .abs_i  (reg_val),
    .next_o (pc_nxt),
    .call_o (is_call)
  );

  // All three outputs are registered and change together on the update edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o      <= ZERO;
      link_o    <= ZERO;
      link_wr_o <= 1'b0;
    end else begin
      link_wr_o <= upd_en & is_call;
      if (upd_en) begin
        pc_o   <= pc_nxt;
        link_o <= pc_inc;
      end
    end
  end

  // Checks

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pc_o == ZERO && link_o == ZERO && !link_wr_o));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> ($stable(pc_o) && $stable(link_o) && !link_wr_o));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && xfer_kind == 2'd0) |=> pc_o == PC_W'($past(pc_o) + ONE));

  assert_rel_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_en && xfer_kind == 2'd1 && br_taken)
      |=> pc_o == PC_W'($past(pc_o) + $past(br_ofs)));

  assert_rel_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_en && xfer_kind == 2'd1 && !br_taken)
      |=> pc_o == PC_W'($past(pc_o) + ONE));

  assert_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_en && xfer_kind == 2'd2) |=> (pc_o == $past(reg_val) && !link_wr_o));

  assert_call_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && xfer_kind == 2'd3) |=> (pc_o == $past(reg_val) && link_wr_o));

  assert_link_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    link_wr_o |-> ($past(upd_en) && $past(xfer_kind) == 2'd3));

  assert_link_value_R8: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> link_o == PC_W'($past(pc_o) + ONE));

endmodule

// File: tb/pc_next_unit_test.sv
module pc_next_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] pc;
    logic [W-1:0] link;
    logic         wr;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         upd_en = 1'b0;
  logic [1:0]   xfer_kind = 2'd0;
  logic         br_taken = 1'b0;
  logic [W-1:0] br_ofs = '0;
  logic [W-1:0] reg_val = '0;
  logic [W-1:0] pc_o;
  logic [W-1:0] link_o;
  logic         link_wr_o;

  int checks = 0;
  int fails  = 0;
  exp_t sb[$];
  logic [W-1:0] m_pc = '0;
  logic [W-1:0] m_link = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit #(.PC_W(W)) uut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .xfer_kind(xfer_kind),
    .br_taken(br_taken), .br_ofs(br_ofs), .reg_val(reg_val),
    .pc_o(pc_o), .link_o(link_o), .link_wr_o(link_wr_o)
  );

  // Driver: applies one instruction at the falling edge and queues the result
  // the reference model expects after the following rising edge.
  task automatic step(input logic en, input logic [1:0] k, input logic t,
                      input logic [W-1:0] ofs, input logic [W-1:0] rv,
                      input string req);
    exp_t e;
    @(negedge clk);
    upd_en = en; xfer_kind = k; br_taken = t; br_ofs = ofs; reg_val = rv;
    e.wr = 1'b0;
    if (en) begin
      m_link = m_pc + 16'd1;
      case (k)
        2'd0: m_pc = m_pc + 16'd1;
        2'd1: m_pc = t ? m_pc + ofs : m_pc + 16'd1;
        default: m_pc = rv;
      endcase
      e.wr = (k == 2'd3);
    end
    e.pc = m_pc; e.link = m_link; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: samples one time unit after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (pc_o !== e.pc || link_o !== e.link || link_wr_o !== e.wr) begin
          fails++;
          $display("FAIL %s: pc=%h link=%h wr=%b, expected pc=%h link=%h wr=%b",
                   e.req, pc_o, link_o, link_wr_o, e.pc, e.link, e.wr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (pc_o !== 16'h0 || link_o !== 16'h0 || link_wr_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: pc=%h link=%h wr=%b, expected 0000 0000 0", pc_o, link_o, link_wr_o);
    end
    @(negedge clk); rst = 1'b0;

    step(1, 2'd0, 0, 16'h0,    16'h0,    "R3 step");
    step(1, 2'd0, 1, 16'h0,    16'h0,    "R3/R9 step flag ignored");
    step(1, 2'd1, 1, 16'h0005, 16'h0,    "R4 forward");
    step(1, 2'd1, 1, 16'hFFFD, 16'h0,    "R4 backward");
    step(1, 2'd1, 0, 16'h0040, 16'h0,    "R5 not taken");
    step(0, 2'd2, 1, 16'h0,    16'h1234, "R2 hold jump");
    step(0, 2'd3, 0, 16'h0,    16'h4321, "R2 hold call");
    step(1, 2'd2, 1, 16'h0077, 16'h0100, "R6/R9 jump flag ignored");
    step(1, 2'd3, 1, 16'h0,    16'h0200, "R7 call");
    step(1, 2'd0, 0, 16'h0,    16'h0,    "R7 pulse ends");
    step(1, 2'd3, 0, 16'h0,    16'h0201, "R8 call to self");
    step(1, 2'd2, 0, 16'h0,    16'hFFFF, "R6 jump top");
    step(1, 2'd0, 0, 16'h0,    16'h0,    "R3 wrap");
    step(1, 2'd1, 1, 16'hFFFE, 16'h0,    "R4 wrap");
    step(0, 2'd0, 0, 16'h0,    16'h0,    "R2 idle");
    step(1, 2'd3, 0, 16'h0,    16'h0010, "R7 call again");
    step(0, 2'd3, 0, 16'h0,    16'h0020, "R2 pulse one cycle");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule